// File: doc/BRIEF.md
# Automatic Loop Code Detector

This block watches the recovered receive bit stream of a line interface for two repeating in-band codes: one that asks the far end to be looped back, and one that asks for the loop to be released. Each code is up to 16 bits long, with a programmable length and pattern. A code counts as present once the most recent bits match it. From then on, every received bit is checked against the code's continuing phase, and a small number of line errors is tolerated.

Each code has its own duration timer that counts seconds ticks while the code stays present. When the loop-up timer reaches the hold limit (five ticks by default), the block raises its remote-loopback request. When the loop-down timer reaches the limit, the request drops. Deasserting the automatic enable clears the request at once and restarts all detection. A testbench can use a short tick, because the tick is an input and the limit is a parameter.

Top module: `loop_code_detect`

## Requirements
- R1: After synchronous reset, `rlb_active`, `up_lock`, `dn_lock`, `up_qual` and `dn_qual` are all 0.
- R2: A detector's lock flag rises one clock after the valid bit that makes the last N valid bits since the last clear equal the code's low N bits. The code is sent starting with bit N-1 and ending with bit 0, at any bit phase. N is the length input, with 0 taken as 1 and values above 16 taken as 16. Loop-down code `111100` (N=6) and loop-up code `11000` (N=5) each lock only their own detector.
- R3: Cycles with `bit_vld` low change no detector state, whatever `bit_in` carries.
- R4: While a detector is locked, each valid bit is compared with the code bit its phase predicts. Up to ERR_MAX (3) mismatches in each run of WIN_BITS (128) locked bits keep the lock. The mismatch count restarts at each window boundary. The 4th mismatch within one window drops the lock one clock later.
- R5: A detector's qualified flag rises in the same clock edge that samples its HOLD_TICKS-th (5th) `tick` counted while its lock flag is high. Losing the lock clears both the tick count and the flag.
- R6: With `enable` high and the request clear, `rlb_active` rises one clock after `up_qual` is high.
- R7: With the request set, `rlb_active` falls one clock after `dn_qual` is high.
- R8: `enable` low clears `rlb_active`, both lock flags and both qualified flags in the next clock, and keeps them clear. Detection starts again from nothing when `enable` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Automatic loopback enable |
| bit_vld | input | 1 | Recovered bit strobe |
| bit_in | input | 1 | Recovered data bit |
| tick | input | 1 | One-cycle seconds tick |
| up_code | input | 16 | Loop-up pattern, bit N-1 first |
| up_len | input | 5 | Loop-up length |
| dn_code | input | 16 | Loop-down pattern, bit N-1 first |
| dn_len | input | 5 | Loop-down length |
| rlb_active | output | 1 | Automatic remote-loopback request |
| up_lock | output | 1 | Loop-up code present |
| dn_lock | output | 1 | Loop-down code present |
| up_qual | output | 1 | Loop-up held for the limit |
| dn_qual | output | 1 | Loop-down held for the limit |

## Verification
Results arrive at fixed points:
- A lock flag changes one clock after the bit that completes a match or supplies the fatal mismatch.
- A qualified flag changes in the same edge that samples the limit tick.
- The loopback request follows one clock after the qualified flag.

The bench drives each input on a falling edge and samples one falling edge later. Each request check therefore reads the state at the qualifying edge first, and then reads again after one idle cycle.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  localparam int unsigned NUM_DET = 2;
  localparam int unsigned DET_UP  = 0;
  localparam int unsigned DET_DN  = 1;
endpackage

// File: rtl/lcd_code_match.sv
module lcd_code_match #(
  parameter int unsigned CODE_W   = 16,
  parameter int unsigned WIN_BITS = 128,
  parameter int unsigned ERR_MAX  = 3,
  localparam int unsigned LEN_W   = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [CODE_W-1:0] code,
  input  logic [LEN_W-1:0]  len,
  output logic              locked
);
  localparam int unsigned PH_W = $clog2(CODE_W);
  localparam int unsigned WC_W = $clog2(WIN_BITS);
  localparam int unsigned EC_W = $clog2(ERR_MAX + 2);
  localparam logic [EC_W-1:0] ERR_LIM  = EC_W'(ERR_MAX);
  localparam logic [WC_W-1:0] WIN_LAST = WC_W'(WIN_BITS - 1);

  logic [CODE_W-1:0] hist, new_hist, mask;
  logic [LEN_W-1:0]  fill, fill_nx, eff_len;
  logic [PH_W-1:0]   ph, ph_top;
  logic [WC_W-1:0]   wcnt;
  logic [EC_W-1:0]   err_cnt, err_nx;
  logic              acquire, mism;

  always_comb begin
    if (len == '0)                      eff_len = LEN_W'(1);
    else if (len > LEN_W'(CODE_W))      eff_len = LEN_W'(CODE_W);
    else                                eff_len = len;
    for (int i = 0; i < CODE_W; i++) mask[i] = (i < int'(eff_len));
    new_hist = {hist[CODE_W-2:0], bit_in};
    fill_nx  = (fill == LEN_W'(CODE_W)) ? fill : fill + LEN_W'(1);
    acquire  = (fill_nx >= eff_len) && (((new_hist ^ code) & mask) == '0);
    ph_top   = PH_W'(eff_len - LEN_W'(1));
    mism     = (bit_in != code[ph]);
    err_nx   = err_cnt + EC_W'(mism);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      hist    <= '0;
      fill    <= '0;
      locked  <= 1'b0;
      ph      <= '0;
      wcnt    <= '0;
      err_cnt <= '0;
    end else if (bit_vld) begin
      hist <= new_hist;
      fill <= fill_nx;
      if (!locked) begin
        if (acquire) begin
          locked  <= 1'b1;
          ph      <= ph_top;
          wcnt    <= '0;
          err_cnt <= '0;
        end
      end else if (err_nx > ERR_LIM) begin
        locked  <= 1'b0;
        wcnt    <= '0;
        err_cnt <= '0;
      end else begin
        ph      <= (ph == '0) ? ph_top : ph - PH_W'(1);
        wcnt    <= (wcnt == WIN_LAST) ? '0 : wcnt + WC_W'(1);
        err_cnt <= (wcnt == WIN_LAST) ? '0 : err_nx;
      end
    end
  end
endmodule

// File: rtl/lcd_hold_timer.sv
module lcd_hold_timer #(
  parameter int unsigned HOLD_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic locked,
  input  logic tick,
  output logic qual
);
  localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_TICKS);

  logic [CNT_W-1:0] cnt, cnt_nx;

  always_comb begin
    if (clr || !locked)             cnt_nx = '0;
    else if (tick && cnt != LIMIT)  cnt_nx = cnt + CNT_W'(1);
    else                            cnt_nx = cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      qual <= (cnt_nx == LIMIT);
    end
  end
endmodule

// File: rtl/loop_code_detect.sv
module loop_code_detect
  import lcd_pkg::*;
#(
  parameter int unsigned CODE_W     = 16,
  parameter int unsigned HOLD_TICKS = 5,
  parameter int unsigned WIN_BITS   = 128,
  parameter int unsigned ERR_MAX    = 3,
  localparam int unsigned LEN_W     = $clog2(CODE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic              tick,
  input  logic [CODE_W-1:0] up_code,
  input  logic [LEN_W-1:0]  up_len,
  input  logic [CODE_W-1:0] dn_code,
  input  logic [LEN_W-1:0]  dn_len,
  output logic              rlb_active,
  output logic              up_lock,
  output logic              dn_lock,
  output logic              up_qual,
  output logic              dn_qual
);
  logic [CODE_W-1:0] det_code [NUM_DET];
  logic [LEN_W-1:0]  det_len  [NUM_DET];
  logic [NUM_DET-1:0] det_lock, det_qual;
  logic clr;

  always_comb begin
    clr              = !enable;
    det_code[DET_UP] = up_code;
    det_len[DET_UP]  = up_len;
    det_code[DET_DN] = dn_code;
    det_len[DET_DN]  = dn_len;
  end

  for (genvar g = 0; g < NUM_DET; g++) begin : g_det
    lcd_code_match #(
      .CODE_W(CODE_W), .WIN_BITS(WIN_BITS), .ERR_MAX(ERR_MAX)
    ) u_match (
      .clk(clk), .rst(rst), .clr(clr), .bit_vld(bit_vld), .bit_in(bit_in),
      .code(det_code[g]), .len(det_len[g]), .locked(det_lock[g])
    );
    lcd_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
      .clk(clk), .rst(rst), .clr(clr), .locked(det_lock[g]),
      .tick(tick), .qual(det_qual[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) rlb_active <= 1'b0;
    else if (rlb_active) rlb_active <= !det_qual[DET_DN];
    else                 rlb_active <= det_qual[DET_UP];
  end

  assign up_lock = det_lock[DET_UP];
  assign dn_lock = det_lock[DET_DN];
  assign up_qual = det_qual[DET_UP];
  assign dn_qual = det_qual[DET_DN];
endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic bit_vld,
  input logic rlb_active,
  input logic up_lock,
  input logic dn_lock,
  input logic up_qual,
  input logic dn_qual
);
  p_lock_on_valid_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(up_lock) || $rose(dn_lock)) |-> $past(bit_vld));

  p_idle_no_change_r3: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && enable) |=> ($stable(up_lock) && $stable(dn_lock)));

  p_up_qual_locked_r5: assert property (@(posedge clk) disable iff (rst)
    up_qual |-> $past(up_lock));

  p_dn_qual_locked_r5: assert property (@(posedge clk) disable iff (rst)
    dn_qual |-> $past(dn_lock));

  p_entry_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(rlb_active) |-> $past(up_qual && enable));

  p_exit_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rlb_active) |-> $past(dn_qual || !enable));

  p_disable_clears_r8: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!rlb_active && !up_lock && !dn_lock && !up_qual && !dn_qual));
endmodule

bind loop_code_detect lcd_checker u_chk (
  .clk(clk), .rst(rst), .enable(enable), .bit_vld(bit_vld),
  .rlb_active(rlb_active), .up_lock(up_lock), .dn_lock(dn_lock),
  .up_qual(up_qual), .dn_qual(dn_qual)
);

// File: tb/loop_code_detect_tb.sv
module loop_code_detect_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, enable, bit_vld, bit_in, tick;
  logic [15:0] up_code, dn_code;
  logic [4:0]  up_len, dn_len;
  logic rlb_active, up_lock, dn_lock, up_qual, dn_qual;
  int checks = 0;
  int errors = 0;

  localparam logic [15:0] UPC = 16'h0018;  // 11000
  localparam logic [15:0] DNC = 16'h003C;  // 111100

  always #(CLK_PERIOD / 2) clk = ~clk;

  loop_code_detect u_dut (
    .clk(clk), .rst(rst), .enable(enable), .bit_vld(bit_vld), .bit_in(bit_in),
    .tick(tick), .up_code(up_code), .up_len(up_len), .dn_code(dn_code),
    .dn_len(dn_len), .rlb_active(rlb_active), .up_lock(up_lock),
    .dn_lock(dn_lock), .up_qual(up_qual), .dn_qual(dn_qual)
  );

  task automatic chk(input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic v = 1'b1);
    bit_vld = v;
    bit_in  = b;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_code(input logic [15:0] c, input int n, input int reps,
                           input logic [15:0] flip = '0);
    for (int r = 0; r < reps; r++)
      for (int i = n - 1; i >= 0; i--) send_bit(c[i] ^ flip[i]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic restart();
    enable = 1'b0;
    @(negedge clk);
    enable = 1'b1;
  endtask

  // four ticks with code between, then the fifth; checks the hold window
  task automatic hold_code(input logic [15:0] c, input int n, input string tag);
    for (int k = 0; k < 4; k++) begin
      send_code(c, n, 2);
      pulse_tick();
    end
    chk({tag, " qual before 5th tick"}, (c == UPC) ? up_qual : dn_qual, 1'b0);
    send_code(c, n, 2);
    pulse_tick();
    chk({tag, " qual at 5th tick"}, (c == UPC) ? up_qual : dn_qual, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 rlb_active", rlb_active, 1'b0);
    chk("R1 up_lock", up_lock, 1'b0);
    chk("R1 dn_lock", dn_lock, 1'b0);
    chk("R1 up_qual", up_qual, 1'b0);
    chk("R1 dn_qual", dn_qual, 1'b0);
  endtask

  task automatic t_lock_phase();
    restart();
    send_bit(1'b0);
    send_bit(1'b1);
    send_code(UPC, 5, 1, 16'h0000);
    chk("R2 up_lock after full code at odd phase", up_lock, 1'b1);
    chk("R2 dn_lock stays low on loop-up stream", dn_lock, 1'b0);
    send_code(DNC, 6, 2);
    chk("R2 dn_lock on loop-down code", dn_lock, 1'b1);
  endtask

  task automatic t_len_bounds();
    up_code = 16'hA5C3;
    up_len  = 5'd16;
    restart();
    for (int i = 15; i >= 1; i--) send_bit(up_code[i]);
    chk("R2 len16 not locked after 15 bits", up_lock, 1'b0);
    send_bit(up_code[0]);
    chk("R2 len16 locked after 16 bits", up_lock, 1'b1);
    up_code = 16'h0001;
    up_len  = 5'd1;
    restart();
    send_bit(1'b0);
    chk("R2 len1 no lock on 0", up_lock, 1'b0);
    send_bit(1'b1);
    chk("R2 len1 lock on 1", up_lock, 1'b1);
    up_code = UPC;
    up_len  = 5'd5;
  endtask

  task automatic t_entry();
    restart();
    send_code(UPC, 5, 1);
    hold_code(UPC, 5, "R5 up");
    chk("R6 rlb_active not yet at qual edge", rlb_active, 1'b0);
    idle(1);
    chk("R6 rlb_active one clock after qual", rlb_active, 1'b1);
  endtask

  task automatic t_vld_ignore();
    // next expected bits 1,1,0,0,0: send the complement with strobe low
    send_bit(1'b0, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b0);
    chk("R3 up_lock kept across unstrobed bits", up_lock, 1'b1);
    send_code(UPC, 5, 1);
    chk("R3 lock still in phase afterwards", up_lock, 1'b1);
  endtask

  task automatic t_errors();
    restart();
    send_code(UPC, 5, 1);
    send_code(UPC, 5, 1, 16'h0015);
    chk("R4 three errors tolerated", up_lock, 1'b1);
    send_code(UPC, 5, 27);
    send_code(UPC, 5, 1, 16'h0015);
    chk("R4 window restart allows three more", up_lock, 1'b1);
    send_code(UPC, 5, 30);
    send_bit(1'b0);
    send_bit(1'b0);
    send_bit(1'b1);
    chk("R4 three errors in new window keep lock", up_lock, 1'b1);
    send_bit(1'b1);
    chk("R4 fourth error drops lock", up_lock, 1'b0);
  endtask

  task automatic t_exit();
    restart();
    send_code(UPC, 5, 1);
    hold_code(UPC, 5, "R5 up");
    idle(1);
    chk("R6 active before loop-down", rlb_active, 1'b1);
    send_code(DNC, 6, 1);
    chk("R2 dn_lock during loop-down", dn_lock, 1'b1);
    hold_code(DNC, 6, "R5 dn");
    chk("R7 active held at dn qual edge", rlb_active, 1'b1);
    idle(1);
    chk("R7 active cleared after dn qual", rlb_active, 1'b0);
    chk("R5 up_qual cleared after lock loss", up_qual, 1'b0);
  endtask

  task automatic t_disable();
    send_code(UPC, 5, 3);
    hold_code(UPC, 5, "R5 up");
    idle(1);
    chk("R6 active again", rlb_active, 1'b1);
    enable = 1'b0;
    idle(1);
    chk("R8 active cleared", rlb_active, 1'b0);
    chk("R8 up_lock cleared", up_lock, 1'b0);
    chk("R8 up_qual cleared", up_qual, 1'b0);
    for (int k = 0; k < 6; k++) begin
      send_code(UPC, 5, 2);
      pulse_tick();
    end
    chk("R8 code ignored while disabled", rlb_active, 1'b0);
    chk("R8 no lock while disabled", up_lock, 1'b0);
    enable = 1'b1;
    send_code(UPC, 5, 1);
    hold_code(UPC, 5, "R8 restart count");
    idle(1);
    chk("R8 active after full new hold", rlb_active, 1'b1);
  endtask

  initial begin
    rst = 1'b1; enable = 1'b0; bit_vld = 1'b0; bit_in = 1'b0; tick = 1'b0;
    up_code = UPC; up_len = 5'd5; dn_code = DNC; dn_len = 5'd6;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lock_phase();
    t_len_bounds();
    t_entry();
    t_vld_ignore();
    t_errors();
    t_exit();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule